// File: doc/BRIEF.md
# Security-Banked Distributor Control Register

This block holds the top-level control word of an interrupt distributor that runs with two security states and with affinity routing permanently on. The word carries three group-enable bits, two affinity-routing flags and a one-way security-disable flag. A register port with a secure attribute reads and writes it. Secure and non-secure accesses see different read views and are allowed to change different bits. When security-disable is set, the block becomes a single-security design until the next reset.

The same port also returns a read-only type word and a fixed identification word. The current group enables and the security-disable flag are driven out continuously so that the rest of the distributor can act on them. Word offsets: 0 is the control word, 1 is the type word, 2 is the identification word, and every other offset is unmapped.

Top module: `dist_ctl_bank`

## Requirements
- R1: After synchronous reset, a secure read of the control word returns 0x0000_0030 and all four state outputs are low. Control word bits: 0 is Group 0 enable, 1 is non-secure Group 1 enable, 2 is secure Group 1 enable, 4 is secure affinity routing, 5 is non-secure affinity routing, 6 is security-disable, 31 is write-pending.
- R2: While security-disable is 0, a secure write to offset 0 replaces bits 0, 1 and 2 with the written values. Bits 4 and 5 keep reading 1 whatever is written. Bit 31 always reads 0.
- R3: While security-disable is 0, a non-secure write to offset 0 changes only bit 1.
- R4: While security-disable is 0, a non-secure read of offset 0 returns the stored word masked to bits 31, 4 and 1. All other bits read 0.
- R5: A secure write that sets bit 6 also clears bit 2 and bit 5 in the same update, even when the same write sets bit 2.
- R6: Once security-disable is 1, no write of any kind clears it. Only reset returns it to 0.
- R7: While security-disable is 1, any write to offset 0 changes only bits 0 and 1. Secure and non-secure reads both return the full stored word.
- R8: Offset 1 reads 0x03F8_0000, plus bit 10 set when security-disable is 0, plus (NUM_IRQ/32 − 1) in bits [4:0]. With the default NUM_IRQ of 256 this gives 0x03F8_0407 or 0x03F8_0007.
- R9: Writes to offsets 1, 2 and unmapped offsets change no state. Offset 2 always reads the IDENT parameter value (default 0x0100_0A5C).
- R10: A write is visible on reads and outputs from the cycle after the clock edge that accepts it. Without a write to offset 0, the outputs hold their values.
- R11: Unmapped offsets read 0, and rdata is 0 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, accepted at the rising edge |
| rd_en | input | 1 | Read enable; rdata is 0 when low |
| addr | input | ADDR_W | Word offset of the access |
| secure | input | 1 | Access is secure when high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr/secure |
| grp0_en | output | 1 | Group 0 enable |
| grp1ns_en | output | 1 | Non-secure Group 1 enable |
| grp1s_en | output | 1 | Secure Group 1 enable |
| sec_dis | output | 1 | Security-disable flag |

## Verification
The hardest case to reach is the one-way transition. Once security-disable is set, the block can never return to two-state behaviour except through reset, so purely random writes would leave almost the whole run in single-security mode. The stimulus handles this by re-applying reset at regular intervals and by biasing the bit-6 value in random writes low, so that both modes and the transition itself are visited many times. Directed steps cover the write that sets bit 6 and bit 2 together, and non-secure attempts to reach bits 0, 2 and 6.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

    localparam int WORD_W = 32;

    localparam int B_G0    = 0;
    localparam int B_G1NS  = 1;
    localparam int B_G1S   = 2;
    localparam int B_ARES  = 4;
    localparam int B_ARENS = 5;
    localparam int B_DS    = 6;
    localparam int B_WPEND = 31;

    localparam logic [WORD_W-1:0] NS_VIEW_MASK = 32'h8000_0012;
    localparam logic [WORD_W-1:0] TYPE_FIXED   = 32'h03F8_0000;
    localparam int                TYPE_SEC_BIT = 10;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_TYPE  = 2'd1,
        SEL_IDENT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ds;
        logic are_ns;
        logic g1s;
        logic g1ns;
        logic g0;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{ds: 1'b0, are_ns: 1'b1, g1s: 1'b0,
                                         g1ns: 1'b0, g0: 1'b0};

    function automatic logic [WORD_W-1:0] ctl_pack(input ctl_state_t s);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[B_G0]    = s.g0;
        w[B_G1NS]  = s.g1ns;
        w[B_G1S]   = s.g1s;
        w[B_ARES]  = 1'b1;
        w[B_ARENS] = s.are_ns;
        w[B_DS]    = s.ds;
        w[B_WPEND] = 1'b0;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] write_mask(input logic ds, input logic secure);
        logic [WORD_W-1:0] m;
        m = '0;
        if (ds) begin
            m[B_G0]   = 1'b1;
            m[B_G1NS] = 1'b1;
        end else if (secure) begin
            m[B_G0]   = 1'b1;
            m[B_G1NS] = 1'b1;
            m[B_G1S]  = 1'b1;
            m[B_DS]   = 1'b1;
        end else begin
            m[B_G1NS] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dctl_wr_policy.sv
module dctl_wr_policy
    import dctl_pkg::*;
(
    input  ctl_state_t          cur,
    input  logic                wr_hit,
    input  logic                secure,
    input  logic [WORD_W-1:0]   wdata,
    output ctl_state_t          nxt
);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] merged;
    logic              ds_rising;

    always_comb begin
        mask      = write_mask(cur.ds, secure);
        merged    = (ctl_pack(cur) & ~mask) | (wdata & mask);
        ds_rising = wr_hit && merged[B_DS] && !cur.ds;
        nxt       = cur;
        if (wr_hit) begin
            nxt.g0   = merged[B_G0];
            nxt.g1ns = merged[B_G1NS];
            nxt.g1s  = merged[B_G1S];
            nxt.ds   = cur.ds | merged[B_DS];
        end
        if (ds_rising) begin
            nxt.g1s    = 1'b0;
            nxt.are_ns = 1'b0;
        end
    end
endmodule

// File: rtl/dctl_type_gen.sv
module dctl_type_gen
    import dctl_pkg::*;
#(
    parameter int NUM_IRQ = 256
) (
    input  logic              ds,
    output logic [WORD_W-1:0] type_word
);
    localparam int          LINES   = (NUM_IRQ / 32) - 1;
    localparam logic [4:0]  LINES_F = 5'(LINES);

    always_comb begin
        type_word               = TYPE_FIXED;
        type_word[TYPE_SEC_BIT] = ~ds;
        type_word[4:0]          = LINES_F;
    end
endmodule

// File: rtl/dctl_rd_view.sv
module dctl_rd_view
    import dctl_pkg::*;
#(
    parameter logic [31:0] IDENT = 32'h0100_0A5C
) (
    input  reg_sel_e          sel,
    input  logic              rd_en,
    input  logic              secure,
    input  logic              ds,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic [WORD_W-1:0] type_word,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] ctl_view;

    always_comb begin
        ctl_view = (!secure && !ds) ? (ctl_word & NS_VIEW_MASK) : ctl_word;
        unique case (sel)
            SEL_CTRL:  rdata = ctl_view;
            SEL_TYPE:  rdata = type_word;
            SEL_IDENT: rdata = IDENT;
            default:   rdata = '0;
        endcase
        if (!rd_en) rdata = '0;
    end
endmodule

// File: rtl/dist_ctl_bank.sv
module dist_ctl_bank
    import dctl_pkg::*;
#(
    parameter int          ADDR_W  = 4,
    parameter int          NUM_IRQ = 256,
    parameter logic [31:0] IDENT   = 32'h0100_0A5C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              secure,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              grp0_en,
    output logic              grp1ns_en,
    output logic              grp1s_en,
    output logic              sec_dis
);
    localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_TYPE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_IDENT = ADDR_W'(2);

    ctl_state_t        state_q;
    ctl_state_t        state_d;
    reg_sel_e          sel;
    logic              wr_hit;
    logic [WORD_W-1:0] type_word;

    always_comb begin
        if (addr == OFS_CTRL)       sel = SEL_CTRL;
        else if (addr == OFS_TYPE)  sel = SEL_TYPE;
        else if (addr == OFS_IDENT) sel = SEL_IDENT;
        else                        sel = SEL_NONE;
    end

    assign wr_hit = wr_en && (sel == SEL_CTRL);

    dctl_wr_policy wr_i (
        .cur    (state_q),
        .wr_hit (wr_hit),
        .secure (secure),
        .wdata  (wdata),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= CTL_RESET;
        else     state_q <= state_d;
    end

    dctl_type_gen #(.NUM_IRQ(NUM_IRQ)) type_i (
        .ds        (state_q.ds),
        .type_word (type_word)
    );

    dctl_rd_view #(.IDENT(IDENT)) rd_i (
        .sel       (sel),
        .rd_en     (rd_en),
        .secure    (secure),
        .ds        (state_q.ds),
        .ctl_word  (ctl_pack(state_q)),
        .type_word (type_word),
        .rdata     (rdata)
    );

    assign grp0_en   = state_q.g0;
    assign grp1ns_en = state_q.g1ns;
    assign grp1s_en  = state_q.g1s;
    assign sec_dis   = state_q.ds;
endmodule

// File: rtl/dist_ctl_bank_chk.sv
module dist_ctl_bank_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              secure,
    input logic [31:0]       rdata,
    input logic              grp0_en,
    input logic              grp1ns_en,
    input logic              grp1s_en,
    input logic              sec_dis
);
    logic ctl_wr;
    assign ctl_wr = wr_en && (addr == '0);

    AST_DS_STICKY: assert property (@(posedge clk) disable iff (rst)
        sec_dis |=> sec_dis);                                              // R6

    AST_DS_CLEARS_G1S: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_dis) |-> !grp1s_en);                                     // R5

    AST_NS_WRITE_NARROW: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !secure && !sec_dis) |=>
            ($stable(grp0_en) && $stable(grp1s_en) && $stable(sec_dis)));  // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> ($stable(grp0_en) && $stable(grp1ns_en) &&
                     $stable(grp1s_en) && $stable(sec_dis)));              // R10

    AST_NS_VIEW_MASKED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == '0 && !secure && !sec_dis) |->
            ((rdata & ~32'h8000_0012) == 32'h0));                          // R4

    AST_SINGLE_NO_G1S: assert property (@(posedge clk) disable iff (rst)
        (sec_dis && !$rose(sec_dis)) |-> !grp1s_en);                       // R7

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == 32'h0));                                      // R11
endmodule

bind dist_ctl_bank dist_ctl_bank_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .secure    (secure),
    .rdata     (rdata),
    .grp0_en   (grp0_en),
    .grp1ns_en (grp1ns_en),
    .grp1s_en  (grp1s_en),
    .sec_dis   (sec_dis)
);

// File: tb/dist_ctl_bank_tb_top.sv
module dist_ctl_bank_tb_top;
    localparam int          ADDR_W  = 4;
    localparam int          NUM_IRQ = 256;
    localparam logic [31:0] IDENT   = 32'h0100_0A5C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              secure = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              grp0_en, grp1ns_en, grp1s_en, sec_dis;

    int errors = 0;
    int checks = 0;

    // bench model of the stored state
    logic m_g0, m_g1ns, m_g1s, m_are_ns, m_ds;

    always #2 clk = ~clk;

    dist_ctl_bank #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ), .IDENT(IDENT)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .secure(secure), .wdata(wdata), .rdata(rdata), .grp0_en(grp0_en),
        .grp1ns_en(grp1ns_en), .grp1s_en(grp1s_en), .sec_dis(sec_dis)
    );

    function automatic logic [31:0] exp_ctrl(input logic sec);
        logic [31:0] w;
        w = {25'd0, m_ds, m_are_ns, 1'b1, 1'b0, m_g1s, m_g1ns, m_g0};
        if (!sec && !m_ds) w = w & 32'h8000_0012;
        return w;
    endfunction

    function automatic logic [31:0] exp_type();
        return 32'h03F8_0000 | ({31'd0, ~m_ds} << 10) | 32'((NUM_IRQ / 32) - 1);
    endfunction

    function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a, input logic sec);
        case (a)
            ADDR_W'(0): return exp_ctrl(sec);
            ADDR_W'(1): return exp_type();
            ADDR_W'(2): return IDENT;
            default:    return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_g0 = 0; m_g1ns = 0; m_g1s = 0; m_are_ns = 1; m_ds = 0;
    endtask

    task automatic model_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic sec);
        if (a != '0) return;
        if (m_ds) begin
            m_g0 = d[0]; m_g1ns = d[1];
        end else if (sec) begin
            m_g0 = d[0]; m_g1ns = d[1]; m_g1s = d[2];
            if (d[6]) begin
                m_ds = 1; m_g1s = 0; m_are_ns = 0;
            end
        end else begin
            m_g1ns = d[1];
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic sec);
        @(negedge clk);
        addr = a; wdata = d; secure = sec; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d, sec);
    endtask

    task automatic do_read(input string req, input logic [ADDR_W-1:0] a, input logic sec);
        @(negedge clk);
        addr = a; secure = sec; rd_en = 1'b1;
        #1;
        check(req, rdata, exp_read(a, sec));
        rd_en = 1'b0;
    endtask

    task automatic check_outs(input string req);
        check(req, {28'd0, sec_dis, grp1s_en, grp1ns_en, grp0_en},
                   {28'd0, m_ds, m_g1s, m_g1ns, m_g0});
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        do_read("R1", ADDR_W'(0), 1'b1);
        check_outs("R1");

        // R2 secure write of enables; affinity bits stay one
        do_write(ADDR_W'(0), 32'h0000_0007, 1'b1);
        do_read("R2", ADDR_W'(0), 1'b1);
        check_outs("R2");
        do_write(ADDR_W'(0), 32'h8000_0032 & ~32'h0000_0030, 1'b1);
        do_read("R2", ADDR_W'(0), 1'b1);

        // R3 non-secure write touches only bit 1
        do_write(ADDR_W'(0), 32'h0000_0007, 1'b1);
        do_write(ADDR_W'(0), 32'h0000_0040, 1'b0);
        check_outs("R3");
        do_write(ADDR_W'(0), 32'h0000_0000, 1'b0);
        check_outs("R3");
        do_read("R4", ADDR_W'(0), 1'b0);

        // R10 visibility the cycle after the accepting edge
        @(negedge clk);
        addr = '0; wdata = 32'h0000_0002; secure = 1'b1; wr_en = 1'b1;
        #1; check("R10", {31'd0, grp1ns_en}, 32'd0);
        @(negedge clk); wr_en = 1'b0; model_write('0, 32'h0000_0002, 1'b1);
        check("R10", {31'd0, grp1ns_en}, 32'd1);

        // R8 type word, R9 read-only and unmapped writes
        do_read("R8", ADDR_W'(1), 1'b0);
        do_write(ADDR_W'(1), 32'hFFFF_FFFF, 1'b1);
        do_write(ADDR_W'(2), 32'hFFFF_FFFF, 1'b1);
        do_write(ADDR_W'(9), 32'hFFFF_FFFF, 1'b1);
        check_outs("R9");
        do_read("R9", ADDR_W'(2), 1'b1);
        do_read("R11", ADDR_W'(9), 1'b1);

        // R5 set DS together with secure Group 1 enable
        do_write(ADDR_W'(0), 32'h0000_0047, 1'b1);
        check_outs("R5");
        do_read("R5", ADDR_W'(0), 1'b1);
        do_read("R8", ADDR_W'(1), 1'b1);

        // R6 / R7 single-security mode
        do_write(ADDR_W'(0), 32'h0000_0004, 1'b1);
        check_outs("R6");
        do_write(ADDR_W'(0), 32'h0000_0001, 1'b0);
        check_outs("R7");
        do_read("R7", ADDR_W'(0), 1'b0);
        do_reset();
        do_read("R6", ADDR_W'(0), 1'b1);

        // random phase with periodic reset
        for (int i = 0; i < 600; i++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0] d;
            logic s;
            if (i % 50 == 49) do_reset();
            a = ($urandom % 4 == 0) ? ADDR_W'($urandom) : '0;
            d = $urandom;
            if ($urandom % 8 != 0) d[6] = 1'b0;
            s = 1'($urandom);
            if ($urandom % 3 == 0) do_read("R2", a, s);
            else begin
                do_write(a, d, s);
                check_outs("R10");
            end
            do_read("R4", ADDR_W'(0), 1'b0);
            do_read("R7", ADDR_W'(0), 1'b1);
        end

        finish_run();
    end
endmodule